// File: doc/BRIEF.md
# LIN Interrupt Status Controller

This block keeps the interrupt side of a LIN/UART serial controller. The protocol engine sends it one-cycle event pulses: header or identifier done, transmit response done, receive response done, and one pulse for each error cause. The block turns each pulse into a sticky flag. The error causes are held in a separate six-bit error detail register, and the error flag is the OR of that register.

Software reaches three byte-wide registers over a simple register bus that has a read strobe, a write strobe and an address. It clears flags by writing ones to them. One combined interrupt request leaves the block; each flag takes part in it only while its enable bit is set. With the mode input in UART setting, data-register accesses clear flags as a side effect: a read clears the receive and error flags, and a write clears the transmit flag.

Top module: `lin_irq_status`

## Requirements
- R1: After reset, the status, enable and error detail registers all read 0 and `irqOut` is 0.
- R2: A pulse on `evtRx`, `evtTx` or `evtId` sets its flag, and the flag reads 1 from the next cycle on. A pulse on `evtErr[k]` sets detail bit k. The detail bits are: 0 bit error, 1 checksum, 2 parity, 3 sync, 4 timeout, 5 framing.
- R3: Address 0 reads status as {4'b0, err, id, tx, rx}. Address 1 reads the enable register. Address 2 reads {2'b0, detail}. With `regRd` low, `regRdata` is 0.
- R4: The status error flag (bit 3) reads 1 exactly when any error detail bit is 1.
- R5: A status write clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: Clearing the error flag (status write with data bit 3 = 1) clears every error detail bit.
- R7: With `uartMode`=1, a `dataRd` pulse clears the error flag (and so the detail register) and the receive flag, and a `dataWr` pulse clears the transmit flag.
- R8: With `uartMode`=0, `dataRd` and `dataWr` change no flag.
- R9: Enable bits 3..0 (err, id, tx, rx) are written at address 1. Bits 7..4 always read 0.
- R10: `irqOut` is the OR over the four flags of (flag AND enable). A set flag whose enable is 0 does not raise `irqOut`.
- R11: When a set event and a clear reach the same flag or detail bit in the same cycle, the set wins and the bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| uartMode | input | 1 | 1 = UART behaviour, 0 = LIN behaviour |
| evtId | input | 1 | Identifier received / header sent pulse |
| evtTx | input | 1 | Transmit response done pulse |
| evtRx | input | 1 | Receive response done pulse |
| evtErr | input | 6 | Error cause pulses |
| regAddr | input | 2 | Register address |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| dataRd | input | 1 | Data register read strobe |
| dataWr | input | 1 | Data register write strobe |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The flags are set one at a time so that a swapped bit position shows up. Errors are injected as single causes and then as a pair, which tests both the OR into the error flag and the full wipe when that flag is cleared. Data-register strobes are sent in both modes, which separates the UART side effects from the LIN case where they must do nothing. Set events arrive in the same cycle as clears, by a status write and by a UART data read, to test that a set wins. The interrupt is checked with all enables off, with all on, and with only some on, which separates masking from the flag state.

// File: rtl/lin_irq_pkg.sv
package lin_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int ERR_W    = 6;
  localparam int FLAG_W   = 4;
  localparam int BIT_RX   = 0;
  localparam int BIT_TX   = 1;
  localparam int BIT_ID   = 2;
  localparam int BIT_ERR  = 3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DETAIL = 2'd2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_DETAIL
  } rdSel_e;

  typedef struct packed {
    logic [FLAG_W-1:0] clrMask;
    logic              wrEnable;
    logic [FLAG_W-1:0] enData;
    rdSel_e            rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/lin_irq_ctrl.sv
module lin_irq_ctrl
  import lin_irq_pkg::*;
(
  input  logic              uartMode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              dataRd,
  input  logic              dataWr,
  output ctrlStrobe_t       strobe
);
  logic [FLAG_W-1:0] swClr;
  logic [FLAG_W-1:0] uartClr;

  always_comb begin
    swClr = '0;
    if (regWr && regAddr == ADDR_STATUS) swClr = regWdata[FLAG_W-1:0];
    uartClr = '0;
    if (uartMode) begin
      uartClr[BIT_RX]  = dataRd;
      uartClr[BIT_ERR] = dataRd;
      uartClr[BIT_TX]  = dataWr;
    end
  end

  always_comb begin
    strobe.clrMask  = swClr | uartClr;
    strobe.wrEnable = regWr && (regAddr == ADDR_ENABLE);
    strobe.enData   = regWdata[FLAG_W-1:0];
    if (!regRd)                        strobe.rdSel = SEL_NONE;
    else if (regAddr == ADDR_STATUS)   strobe.rdSel = SEL_STATUS;
    else if (regAddr == ADDR_ENABLE)   strobe.rdSel = SEL_ENABLE;
    else if (regAddr == ADDR_DETAIL)   strobe.rdSel = SEL_DETAIL;
    else                               strobe.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/lin_irq_dp.sv
module lin_irq_dp
  import lin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtId,
  input  logic              evtTx,
  input  logic              evtRx,
  input  logic [ERR_W-1:0]  evtErr,
  input  ctrlStrobe_t       strobe,
  output logic [FLAG_W-1:0] flags,
  output logic [ERR_W-1:0]  errDetail,
  output logic [FLAG_W-1:0] enableReg,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] plainFlags;

  assign setVec = {1'b0, evtId, evtTx, evtRx};

  // id, tx, rx flags: one sticky bit each, set beats clear
  for (genvar i = 0; i < BIT_ERR; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               plainFlags[i] <= 1'b0;
      else if (setVec[i])      plainFlags[i] <= 1'b1;
      else if (strobe.clrMask[i]) plainFlags[i] <= 1'b0;
    end
  end
  assign plainFlags[BIT_ERR] = 1'b0;

  // error detail: clearing the error flag wipes all, new causes still land
  for (genvar k = 0; k < ERR_W; k++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        errDetail[k] <= 1'b0;
      else if (evtErr[k])               errDetail[k] <= 1'b1;
      else if (strobe.clrMask[BIT_ERR]) errDetail[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enableReg <= '0;
    else if (strobe.wrEnable) enableReg <= strobe.enData;
  end

  always_comb begin
    flags          = plainFlags;
    flags[BIT_ERR] = |errDetail;
  end

  assign irq = |(flags & enableReg);

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: rdData = DATA_W'(flags);
      SEL_ENABLE: rdData = DATA_W'(enableReg);
      SEL_DETAIL: rdData = DATA_W'(errDetail);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/lin_irq_status.sv
module lin_irq_status
  import lin_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              uartMode,
  input  logic              evtId,
  input  logic              evtTx,
  input  logic              evtRx,
  input  logic [ERR_W-1:0]  evtErr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              dataRd,
  input  logic              dataWr,
  output logic              irqOut
);
  ctrlStrobe_t       strobe;
  logic [FLAG_W-1:0] flags;
  logic [ERR_W-1:0]  errDetail;
  logic [FLAG_W-1:0] enableReg;

  lin_irq_ctrl u_ctrl (
    .uartMode (uartMode),
    .regAddr  (regAddr),
    .regRd    (regRd),
    .regWr    (regWr),
    .regWdata (regWdata),
    .dataRd   (dataRd),
    .dataWr   (dataWr),
    .strobe   (strobe)
  );

  lin_irq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtId     (evtId),
    .evtTx     (evtTx),
    .evtRx     (evtRx),
    .evtErr    (evtErr),
    .strobe    (strobe),
    .flags     (flags),
    .errDetail (errDetail),
    .enableReg (enableReg),
    .rdData    (regRdata),
    .irq       (irqOut)
  );
endmodule

// File: rtl/lin_irq_status_chk.sv
module lin_irq_status_chk
  import lin_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              uartMode,
  input logic              evtTx,
  input logic              evtRx,
  input logic [ERR_W-1:0]  evtErr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRd,
  input logic              regWr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              dataRd,
  input logic              dataWr,
  input logic [FLAG_W-1:0] flags,
  input logic [ERR_W-1:0]  errDetail,
  input logic [FLAG_W-1:0] enableReg,
  input logic              irqOut
);
  a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtRx |=> flags[BIT_RX]);

  a_r11_err_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    evtErr[0] |=> errDetail[0]);

  a_r6_err_wipe: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_STATUS && regWdata[BIT_ERR] && evtErr == '0)
      |=> errDetail == '0);

  a_r7_uart_read: assert property (@(posedge clk) disable iff (!rstN)
    (uartMode && dataRd && !evtRx) |=> !flags[BIT_RX]);

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!evtTx && !regWr && !(uartMode && dataWr)) |=> flags[BIT_TX] == $past(flags[BIT_TX]));

  a_r9_enable_upper: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_ENABLE) |-> regRdata[DATA_W-1:FLAG_W] == '0);

  a_r10_masked: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |-> !irqOut);
endmodule

bind lin_irq_status lin_irq_status_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .uartMode  (uartMode),
  .evtTx     (evtTx),
  .evtRx     (evtRx),
  .evtErr    (evtErr),
  .regAddr   (regAddr),
  .regRd     (regRd),
  .regWr     (regWr),
  .regWdata  (regWdata),
  .regRdata  (regRdata),
  .dataRd    (dataRd),
  .dataWr    (dataWr),
  .flags     (flags),
  .errDetail (errDetail),
  .enableReg (enableReg),
  .irqOut    (irqOut)
);

// File: tb/lin_irq_status_bench.sv
module lin_irq_status_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       uartMode = 1'b0;
  logic       evtId = 1'b0, evtTx = 1'b0, evtRx = 1'b0;
  logic [5:0] evtErr = '0;
  logic [1:0] regAddr = '0;
  logic       regRd = 1'b0, regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       dataRd = 1'b0, dataWr = 1'b0;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  lin_irq_status u_lin_irq_status (
    .clk(clk), .rstN(rstN), .uartMode(uartMode),
    .evtId(evtId), .evtTx(evtTx), .evtRx(evtRx), .evtErr(evtErr),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .dataRd(dataRd), .dataWr(dataWr), .irqOut(irqOut)
  );

  // monitor: compares read data against the scoreboard at the falling edge
  always @(negedge clk) begin
    if (regRd) begin
      if (sbQ.size() == 0) begin
        testsRun++; testsFailed++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        testsRun++;
        if (regRdata !== it.exp) begin
          testsFailed++;
          $display("FAIL %s: got %02h expected %02h", it.tag, regRdata, it.exp);
        end
      end
    end
  end

  task automatic readExp(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    regAddr = a; regRd = 1'b1;
    sbQ.push_back('{exp: e, tag: tag});
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic pulse(input logic id, input logic tx, input logic rx, input logic [5:0] er);
    @(posedge clk); #1;
    evtId = id; evtTx = tx; evtRx = rx; evtErr = er;
    @(posedge clk); #1;
    evtId = 0; evtTx = 0; evtRx = 0; evtErr = '0;
  endtask

  task automatic dataAccess(input logic rd, input logic wr);
    @(posedge clk); #1;
    dataRd = rd; dataWr = wr;
    @(posedge clk); #1;
    dataRd = 0; dataWr = 0;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    testsRun++;
    if (irqOut !== e) begin
      testsFailed++;
      $display("FAIL %s: irqOut got %b expected %b", tag, irqOut, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    checkIrq(1'b0, "R1 irq");
    readExp(2'd0, 8'h00, "R1 status");
    readExp(2'd1, 8'h00, "R1 enable");
    readExp(2'd2, 8'h00, "R1 detail");
    // R2 / R3 flags set one at a time
    pulse(0, 0, 1, '0); readExp(2'd0, 8'h01, "R2 rx bit0");
    pulse(0, 1, 0, '0); readExp(2'd0, 8'h03, "R3 tx bit1");
    pulse(1, 0, 0, '0); readExp(2'd0, 8'h07, "R3 id bit2");
    // R4 parity error
    pulse(0, 0, 0, 6'b000100);
    readExp(2'd2, 8'h04, "R2 detail parity");
    readExp(2'd0, 8'h0F, "R4 err flag");
    // R10 masked, R9 enable upper bits
    checkIrq(1'b0, "R10 masked");
    regWrite(2'd1, 8'hFF);
    readExp(2'd1, 8'h0F, "R9 enable");
    checkIrq(1'b1, "R10 enabled");
    // R5 write-one-to-clear
    regWrite(2'd0, 8'h00); readExp(2'd0, 8'h0F, "R5 zero write");
    regWrite(2'd0, 8'h02); readExp(2'd0, 8'h0D, "R5 clear tx");
    // R6 err clear wipes detail
    pulse(0, 0, 0, 6'b100001);
    readExp(2'd2, 8'h25, "R2 detail pair");
    regWrite(2'd0, 8'h08);
    readExp(2'd0, 8'h05, "R6 status");
    readExp(2'd2, 8'h00, "R6 detail");
    // R8 LIN mode data access has no effect
    pulse(0, 1, 0, 6'b000010);
    dataAccess(1, 1);
    readExp(2'd0, 8'h0F, "R8 lin data access");
    // R7 UART side effects
    uartMode = 1'b1;
    dataAccess(1, 0);
    readExp(2'd0, 8'h06, "R7 uart read");
    readExp(2'd2, 8'h00, "R7 detail");
    dataAccess(0, 1);
    readExp(2'd0, 8'h04, "R7 uart write");
    // R11 set wins over software clear
    @(posedge clk); #1;
    regAddr = 2'd0; regWdata = 8'h01; regWr = 1'b1; evtRx = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0; evtRx = 1'b0;
    readExp(2'd0, 8'h05, "R11 rx set wins");
    // R10 partial enable
    regWrite(2'd1, 8'h01);
    checkIrq(1'b1, "R10 rx enabled");
    regWrite(2'd0, 8'h01);
    checkIrq(1'b0, "R10 id masked");
    // R11 error set wins over uart read clear
    @(posedge clk); #1;
    dataRd = 1'b1; evtErr = 6'b010000;
    @(posedge clk); #1;
    dataRd = 1'b0; evtErr = '0;
    readExp(2'd2, 8'h10, "R11 err set wins");
    // R3 idle read data
    @(negedge clk);
    testsRun++;
    if (regRdata !== 8'h00) begin
      testsFailed++;
      $display("FAIL R3 idle rdata: got %02h expected 00", regRdata);
    end
    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        testsRun++; testsFailed++;
        $display("FAIL watchdog: run hung");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule